// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Decoder

This block is the card-side front end of a PC Card data bus in memory and I/O modes. The host drives two active-low card enables, address bit 0, an attribute-select line and four asynchronous strobes. The block turns each host cycle into one access on a 16-bit internal port. That access carries byte enables, an address-space code and, for writes, a data word with the bytes already steered. For reads it routes the internal read word onto the correct host byte lanes and drives the per-lane output enables for the tri-state pads.

An 8-bit host uses only the low data lane. It can still reach the odd byte of a word: it asserts the first enable with address bit 0 set. A 16-bit host uses both enables, and can also address only the odd byte through the second enable. For I/O cycles the block drives the input-acknowledge line, but only when an external address decoder reports a hit. It also drives the 16-bit-port indication while a wide port is addressed.

All host controls and the host data bus pass through a two-stage synchronizer. A write is committed to the internal port one cycle after the synchronized strobe is seen to return high. The data committed is the data that was present while the strobe was low.

Top module: `pccard_lane_steer`

## Requirements
- R1: With both enables low, the access is a word. `acc_be` = 2'b11, read drives `rdata[7:0]` on host bits 7:0 and `rdata[15:8]` on host bits 15:8 with both lane enables high, and a write delivers `host_din` unchanged.
- R2: With only the first enable low and A0 = 0, `acc_be` = 2'b01. A read drives `rdata[7:0]` on the low lane with only the low lane enable high. A write delivers `host_din[7:0]` in bits 7:0 with bits 15:8 zero.
- R3: With only the first enable low and A0 = 1, `acc_be` = 2'b10. A read drives `rdata[15:8]` on the low lane with only the low lane enable high. A write delivers `host_din[7:0]` in bits 15:8 with bits 7:0 zero.
- R4: With only the second enable low, `acc_be` = 2'b10 whatever A0 is. A read drives `rdata[15:8]` on the high lane with only the high lane enable high. A write delivers `host_din[15:8]` in bits 15:8 with bits 7:0 zero.
- R5: With both enables high, no strobe has any effect: `acc_rd` stays 0, both lane enables stay 0, and no `acc_wr` pulse appears.
- R6: `acc_space` encodes the cycle type. 0 means common memory (output or write enable strobe with attribute select high). 1 means attribute memory (the same strobes with attribute select low). 2 means I/O (I/O read or write strobe with attribute select low). An I/O strobe with attribute select high is ignored: no pulse, no read, no drive.
- R7: Each write strobe that goes low and returns high during a selected cycle gives exactly one single-cycle `acc_wr` pulse. The pulse follows the rising edge and carries the byte enables, space and data present while the strobe was low.
- R8: `inpack_n` is low only during an I/O read with the card selected, attribute select low and `io_hit` high. An I/O read without `io_hit` leaves `inpack_n` high, `acc_rd` low and both lane enables low.
- R9: `iois16_n` is low while the card is selected, attribute select is low and `port_wide` is high, and high otherwise.
- R10: After reset, `acc_wr` and `acc_rd` are 0, `acc_be` is 0, both lane enables are 0, and `inpack_n` and `iois16_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce1_n | input | 1 | First card enable, active low |
| ce2_n | input | 1 | Second card enable (odd byte), active low |
| a0 | input | 1 | Host address bit 0 |
| reg_n | input | 1 | Attribute select, low for attribute or I/O |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| host_din | input | 16 | Host data bus as seen at the pads |
| host_dout | output | 16 | Read data to the pads |
| host_oe_lo | output | 1 | Drive enable for host bits 7:0 |
| host_oe_hi | output | 1 | Drive enable for host bits 15:8 |
| inpack_n | output | 1 | Input acknowledge, active low |
| iois16_n | output | 1 | 16-bit port indication, active low |
| io_hit | input | 1 | External decoder: I/O address belongs to this card |
| port_wide | input | 1 | External decoder: addressed port accepts word or odd-byte access |
| acc_wr | output | 1 | Single-cycle internal write pulse |
| acc_rd | output | 1 | Internal read active |
| acc_be | output | 2 | Internal byte enables (bit 1 = odd byte) |
| acc_space | output | 2 | Space code: 0 common, 1 attribute, 2 I/O |
| acc_wdata | output | 16 | Steered write data, valid with acc_wr |
| acc_rdata | input | 16 | Internal read word |

## Verification
The hardest case is a write whose enables, address bit or data change close to the strobe's rising edge. The committed snapshot must come from the last low sample, not from the bus after release. The stimulus holds data and controls several cycles past the release. It then runs two writes back to back with different lane patterns, each followed by one monitor pop, so that a stale or doubled pulse shows as a scoreboard mismatch. Ignored cycles are covered separately: a write with both enables high and an I/O write with attribute select high. Each must leave the write queue untouched while the monitor still watches for a pulse.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [1:0] {
        SPC_COMMON = 2'd0,
        SPC_ATTR   = 2'd1,
        SPC_IO     = 2'd2
    } space_e;

    // bit positions of host controls inside the synchronized vector
    localparam int unsigned CB_CE1  = 0;
    localparam int unsigned CB_CE2  = 1;
    localparam int unsigned CB_A0   = 2;
    localparam int unsigned CB_REG  = 3;
    localparam int unsigned CB_OE   = 4;
    localparam int unsigned CB_WE   = 5;
    localparam int unsigned CB_IORD = 6;
    localparam int unsigned CB_IOWR = 7;
    localparam int unsigned CTRL_W  = 8;
    // idle host: enables and strobes high, a0 low
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 8'hFB;

endpackage

// File: rtl/pcl_sync.sv
module pcl_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pcl_lane_dec.sv
module pcl_lane_dec (
    input  logic       ce1_n,
    input  logic       ce2_n,
    input  logic       a0,
    output logic       sel,
    output logic [1:0] be,
    output logic       swap
);
    // swap: the low host lane carries the odd byte (8-bit host, odd address)
    always_comb begin
        sel  = !ce1_n || !ce2_n;
        be   = 2'b00;
        swap = 1'b0;
        unique case ({ce2_n, ce1_n})
            2'b00: be = 2'b11;
            2'b10: begin
                be   = a0 ? 2'b10 : 2'b01;
                swap = a0;
            end
            2'b01: be = 2'b10;
            default: be = 2'b00;
        endcase
    end
endmodule

// File: rtl/pcl_rd_steer.sv
module pcl_rd_steer #(
    parameter int unsigned DW = 16,
    localparam int unsigned LW = DW / 2
) (
    input  logic [DW-1:0] rdata,
    input  logic          swap,
    output logic [DW-1:0] lanes
);
    always_comb begin
        lanes[LW-1:0]  = swap ? rdata[DW-1:LW] : rdata[LW-1:0];
        lanes[DW-1:LW] = rdata[DW-1:LW];
    end
endmodule

// File: rtl/pcl_wr_steer.sv
module pcl_wr_steer #(
    parameter int unsigned DW = 16,
    localparam int unsigned LW = DW / 2
) (
    input  logic [DW-1:0] hdata,
    input  logic [1:0]    be,
    input  logic          swap,
    output logic [DW-1:0] wdata
);
    always_comb begin
        wdata[LW-1:0]  = be[0] ? hdata[LW-1:0] : '0;
        wdata[DW-1:LW] = !be[1] ? '0 : (swap ? hdata[LW-1:0] : hdata[DW-1:LW]);
    end
endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
    import pcl_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic          a0,
    input  logic          reg_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          iord_n,
    input  logic          iowr_n,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_oe_lo,
    output logic          host_oe_hi,
    output logic          inpack_n,
    output logic          iois16_n,
    input  logic          io_hit,
    input  logic          port_wide,
    output logic          acc_wr,
    output logic          acc_rd,
    output logic [1:0]    acc_be,
    output logic [1:0]    acc_space,
    output logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] acc_rdata
);
    localparam int unsigned SW = CTRL_W + DW;
    localparam logic [SW-1:0] SYNC_RST = {{DW{1'b0}}, CTRL_IDLE};

    typedef struct packed {
        logic          wr_arm;
        logic [1:0]    wr_be;
        space_e        wr_space;
        logic [DW-1:0] wr_data;
        logic          acc_wr;
        logic          acc_rd;
        logic [1:0]    acc_be;
        space_e        acc_space;
        logic [DW-1:0] acc_wdata;
        logic          oe_lo;
        logic          oe_hi;
        logic [DW-1:0] dout;
        logic          inpack_n;
        logic          iois16_n;
    } state_t;

    localparam state_t ST_RESET = '{
        wr_arm: 1'b0, wr_be: 2'b00, wr_space: SPC_COMMON, wr_data: '0,
        acc_wr: 1'b0, acc_rd: 1'b0, acc_be: 2'b00, acc_space: SPC_COMMON,
        acc_wdata: '0, oe_lo: 1'b0, oe_hi: 1'b0, dout: '0,
        inpack_n: 1'b1, iois16_n: 1'b1
    };

    // synchronized host side
    logic [SW-1:0]     sync_q;
    logic [CTRL_W-1:0] s_ctl;
    logic [DW-1:0]     s_data;

    pcl_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_din, iowr_n, iord_n, we_n, oe_n, reg_n, a0, ce2_n, ce1_n}),
        .dout (sync_q)
    );
    assign s_ctl  = sync_q[CTRL_W-1:0];
    assign s_data = sync_q[SW-1:CTRL_W];

    logic       sel;
    logic [1:0] lane_be;
    logic       lane_swap;

    pcl_lane_dec lane_dec_i (
        .ce1_n(s_ctl[CB_CE1]),
        .ce2_n(s_ctl[CB_CE2]),
        .a0   (s_ctl[CB_A0]),
        .sel  (sel),
        .be   (lane_be),
        .swap (lane_swap)
    );

    logic [DW-1:0] rd_lanes;
    logic [DW-1:0] wr_word;

    pcl_rd_steer #(.DW(DW)) rd_steer_i (
        .rdata(acc_rdata),
        .swap (lane_swap),
        .lanes(rd_lanes)
    );

    pcl_wr_steer #(.DW(DW)) wr_steer_i (
        .hdata(s_data),
        .be   (lane_be),
        .swap (lane_swap),
        .wdata(wr_word)
    );

    state_t st_d, st_q;

    always_comb begin
        logic reg_lo, mem_rd, io_rd, rd_act, strobe_lo, fire;
        space_e mem_space;

        st_d        = st_q;
        st_d.acc_wr = 1'b0;

        reg_lo    = !s_ctl[CB_REG];
        mem_space = reg_lo ? SPC_ATTR : SPC_COMMON;
        mem_rd    = sel && !s_ctl[CB_OE];
        io_rd     = sel && !s_ctl[CB_IORD] && reg_lo;
        rd_act    = mem_rd || (io_rd && io_hit);
        strobe_lo = !s_ctl[CB_WE] || (!s_ctl[CB_IOWR] && reg_lo);
        fire      = st_q.wr_arm && !strobe_lo;

        // snapshot the write while its strobe is low
        if (sel && strobe_lo) begin
            st_d.wr_arm   = 1'b1;
            st_d.wr_be    = lane_be;
            st_d.wr_space = !s_ctl[CB_WE] ? mem_space : SPC_IO;
            st_d.wr_data  = wr_word;
        end

        if (fire) begin
            st_d.wr_arm    = 1'b0;
            st_d.acc_wr    = 1'b1;
            st_d.acc_wdata = st_q.wr_data;
        end

        st_d.acc_rd = rd_act;
        if (fire) begin
            st_d.acc_be    = st_q.wr_be;
            st_d.acc_space = st_q.wr_space;
        end else if (rd_act) begin
            st_d.acc_be    = lane_be;
            st_d.acc_space = mem_rd ? mem_space : SPC_IO;
        end else begin
            st_d.acc_be    = 2'b00;
        end

        st_d.oe_lo    = rd_act && !s_ctl[CB_CE1];
        st_d.oe_hi    = rd_act && !s_ctl[CB_CE2];
        st_d.dout     = rd_act ? rd_lanes : '0;
        st_d.inpack_n = !(io_rd && io_hit);
        st_d.iois16_n = !(sel && reg_lo && port_wide);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign host_dout  = st_q.dout;
    assign host_oe_lo = st_q.oe_lo;
    assign host_oe_hi = st_q.oe_hi;
    assign inpack_n   = st_q.inpack_n;
    assign iois16_n   = st_q.iois16_n;
    assign acc_wr     = st_q.acc_wr;
    assign acc_rd     = st_q.acc_rd;
    assign acc_be     = st_q.acc_be;
    assign acc_space  = st_q.acc_space;
    assign acc_wdata  = st_q.acc_wdata;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker
    import pcl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       acc_wr,
    input logic       acc_rd,
    input logic [1:0] acc_be,
    input logic [1:0] acc_space,
    input logic       host_oe_lo,
    input logic       host_oe_hi,
    input logic       inpack_n
);
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !acc_wr); // R7

    AST_WR_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> acc_be != 2'b00); // R7

    AST_HI_LANE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe_hi |-> (acc_rd && acc_be[1])); // R4

    AST_LO_LANE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe_lo |-> (acc_rd && acc_be != 2'b00)); // R2

    AST_INPACK_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> (acc_rd && acc_space == SPC_IO)); // R8
endmodule

bind pccard_lane_steer pcl_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_be    (acc_be),
    .acc_space (acc_space),
    .host_oe_lo(host_oe_lo),
    .host_oe_hi(host_oe_hi),
    .inpack_n  (inpack_n)
);

// File: tb/pccard_lane_steer_tb_top.sv
module pccard_lane_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, a0 = 1'b0, reg_n = 1'b1;
    logic        oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        host_oe_lo, host_oe_hi, inpack_n, iois16_n;
    logic        io_hit = 1'b0, port_wide = 1'b0;
    logic        acc_wr, acc_rd;
    logic [1:0]  acc_be, acc_space;
    logic [15:0] acc_wdata;
    logic [15:0] acc_rdata = '0;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int pushed = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0]  be;
        logic [1:0]  space;
        logic [15:0] data;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #4 clk = ~clk;

    pccard_lane_steer dut_i (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .a0(a0),
        .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .host_din(host_din), .host_dout(host_dout), .host_oe_lo(host_oe_lo),
        .host_oe_hi(host_oe_hi), .inpack_n(inpack_n), .iois16_n(iois16_n),
        .io_hit(io_hit), .port_wide(port_wide), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_be(acc_be), .acc_space(acc_space), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // expected byte enables from the lane rules (R1..R4)
    function automatic logic [1:0] exp_be(input logic c1, input logic c2, input logic ad);
        if (!c1 && !c2) return 2'b11;
        if (!c1)        return ad ? 2'b10 : 2'b01;
        if (!c2)        return 2'b10;
        return 2'b00;
    endfunction

    // monitor: every write pulse is popped and compared
    always @(negedge clk) begin
        if (rst_n && acc_wr) begin
            pulses++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R6/R7 unexpected write", {14'd0, acc_be, acc_wdata}, 32'd0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk({acc_be, acc_space, acc_wdata} == e, "R7 write item",
                    {12'd0, acc_be, acc_space, acc_wdata}, {12'd0, e});
            end
        end
    end

    task automatic do_read(input logic c1, input logic c2, input logic ad,
                           input logic rg, input bit use_io, input logic hit,
                           input logic [15:0] rd, input string req);
        logic sel, act, e_lo, e_hi;
        logic [1:0] e_be, e_sp;
        logic [7:0] e_low;
        ce1_n = c1; ce2_n = c2; a0 = ad; reg_n = rg; io_hit = hit; acc_rdata = rd;
        settle(1);
        if (use_io) iord_n = 1'b0; else oe_n = 1'b0;
        settle(6);
        sel   = !c1 || !c2;
        act   = sel && (use_io ? (!rg && hit) : 1'b1);
        e_lo  = act && !c1;
        e_hi  = act && !c2;
        e_be  = act ? exp_be(c1, c2, ad) : 2'b00;
        e_sp  = use_io ? 2'd2 : (rg ? 2'd0 : 2'd1);
        e_low = (!c1 && c2 && ad) ? rd[15:8] : rd[7:0];
        chk(acc_rd == act, {req, " acc_rd"}, acc_rd, act);
        chk(host_oe_lo == e_lo, {req, " oe_lo"}, host_oe_lo, e_lo);
        chk(host_oe_hi == e_hi, {req, " oe_hi"}, host_oe_hi, e_hi);
        chk(acc_be == e_be, {req, " be"}, acc_be, e_be);
        if (act) chk(acc_space == e_sp, {req, " space"}, acc_space, e_sp);
        if (e_lo) chk(host_dout[7:0] == e_low, {req, " low lane"}, host_dout[7:0], e_low);
        if (e_hi) chk(host_dout[15:8] == rd[15:8], {req, " high lane"}, host_dout[15:8], rd[15:8]);
        chk(inpack_n == !(use_io && sel && !rg && hit), {req, " R8 inpack_n"},
            inpack_n, !(use_io && sel && !rg && hit));
        oe_n = 1'b1; iord_n = 1'b1;
        settle(5);
        ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1; io_hit = 1'b0;
        settle(5);
    endtask

    task automatic do_write(input logic c1, input logic c2, input logic ad,
                            input logic rg, input bit use_io, input logic [15:0] dat);
        logic [1:0] be;
        logic [15:0] w;
        be = exp_be(c1, c2, ad);
        w  = '0;
        if (be == 2'b11)             w = dat;
        else if (be == 2'b01)        w = {8'h00, dat[7:0]};
        else if (!c1 && ad)          w = {dat[7:0], 8'h00};
        else if (be == 2'b10)        w = {dat[15:8], 8'h00};
        if ((be != 2'b00) && (use_io ? !rg : 1'b1)) begin
            exp_q.push_back({be, use_io ? 2'd2 : (rg ? 2'd0 : 2'd1), w});
            pushed++;
        end
        ce1_n = c1; ce2_n = c2; a0 = ad; reg_n = rg; host_din = dat;
        settle(1);
        if (use_io) iowr_n = 1'b0; else we_n = 1'b0;
        settle(4);
        we_n = 1'b1; iowr_n = 1'b1;
        settle(6);
        ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1; host_din = 16'hDEAD;
        settle(3);
    endtask

    initial begin
        settle(3);
        // R10 reset state
        chk(acc_wr == 1'b0, "R10 acc_wr", acc_wr, 0);
        chk(acc_rd == 1'b0, "R10 acc_rd", acc_rd, 0);
        chk(acc_be == 2'b00, "R10 acc_be", acc_be, 0);
        chk({host_oe_hi, host_oe_lo} == 2'b00, "R10 lane enables", {host_oe_hi, host_oe_lo}, 0);
        chk(inpack_n && iois16_n, "R10 inpack/iois16", {inpack_n, iois16_n}, 2'b11);
        rst_n = 1'b1;
        settle(3);

        do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA55A, "R1 R6 word common read");
        do_read(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h3C12, "R2 R6 even byte attr read");
        do_read(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h9E44, "R3 odd byte low lane read");
        do_read(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h7B01, "R4 odd byte high lane read");
        do_read(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R5 deselected read");
        do_read(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hC0DE, "R8 R6 io read hit");
        do_read(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hC0DE, "R8 io read miss");
        do_read(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234, "R6 io read with reg high");

        // R9 16-bit port indication
        ce1_n = 1'b0; reg_n = 1'b0; port_wide = 1'b1;
        settle(6);
        chk(iois16_n == 1'b0, "R9 wide port", iois16_n, 0);
        port_wide = 1'b0;
        settle(6);
        chk(iois16_n == 1'b1, "R9 narrow port", iois16_n, 1);
        port_wide = 1'b1; reg_n = 1'b1;
        settle(6);
        chk(iois16_n == 1'b1, "R9 reg high", iois16_n, 1);
        ce1_n = 1'b1; reg_n = 1'b0;
        settle(6);
        chk(iois16_n == 1'b1, "R9 deselected", iois16_n, 1);
        reg_n = 1'b1; port_wide = 1'b0;
        settle(4);

        do_write(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8421);  // R1 word common
        do_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h5566);  // R2 even attr
        do_write(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h77A9);  // R3 odd via low lane, io
        do_write(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hB3C4);  // R4 odd via high lane
        do_write(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'hEEEE);  // R5 no pulse
        do_write(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1111);  // R6 io write, reg high: no pulse
        do_write(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2468);  // R7 back to back, io word
        do_write(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h13F7);  // R7 back to back, odd low lane

        settle(10);
        chk(pulses == pushed, "R7 pulse count", pulses, pushed);
        chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule